// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes either the quotient or the remainder of a 64-bit integer division. The operands are treated as signed or unsigned according to the selected operation. A word mode divides only the low 32 bits of each operand and returns that 32-bit result sign-extended to 64 bits. The block strips the signs and divides the magnitudes one bit per clock with a restoring shift-subtract step. It then gives the quotient and remainder the correct signs.

Two operand combinations cannot trap and have fixed results. Both are detected when the operation is accepted and answered on the next cycle, without running the divider. The first is a zero divisor. The second is the most negative signed value divided by minus one.

A client raises `start` for one cycle with the operands, `op` and `word` valid. The block accepts the request only while `busy` is low. A `start` seen while `busy` is high is dropped. This is the only back-pressure rule: the client must wait for `busy` to fall before it sends the next request. The result has no back-pressure. It is valid in the cycle where `done` pulses and stays on `result` until the next completion. A new request may be issued in that same `done` cycle.

Top module: `int_divider`

## Requirements
- R1: While reset is asserted, and after it is released with no request made, `busy` and `done` are 0 and `result` is zero.
- R2: `op` encoding: bit 1 = 0 selects the quotient and bit 1 = 1 selects the remainder; bit 0 = 1 selects unsigned and bit 0 = 0 selects signed. So the codes are 0 signed quotient, 1 unsigned quotient, 2 signed remainder, 3 unsigned remainder. A signed quotient truncates toward zero.
- R3: A signed remainder has the sign of the dividend and a magnitude smaller than that of the divisor. Dividend, divisor, quotient and remainder satisfy dividend = quotient × divisor + remainder.
- R4: A quotient, signed or unsigned, with a zero divisor is all ones.
- R5: A remainder, signed or unsigned, with a zero divisor equals the dividend. In word mode this is the dividend's low 32 bits, sign-extended.
- R6: A signed quotient of the most negative value (of the active width) divided by minus one equals that most negative value, sign-extended in word mode.
- R7: A signed remainder of the most negative value divided by minus one is zero.
- R8: With `word` = 1, only bits 31:0 of each operand are used, as signed or unsigned according to `op` bit 0. Result bits 63:32 are copies of result bit 31.
- R9: A zero-divisor or overflow request raises `done` in the cycle after it is accepted, and `busy` stays low.
- R10: Any other request raises `busy` in the cycle after acceptance. `busy` stays high for N+1 cycles (N = 64, or 32 in word mode). `done` then pulses in the next cycle, with `busy` low.
- R11: A `start` pulse while `busy` is high is ignored. The result that completes belongs to the request that was accepted.
- R12: `done` lasts one cycle, and `result` holds its value after `done` until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted when `busy` is low |
| op | input | 2 | Operation select; bit 1 selects remainder, bit 0 selects unsigned |
| word | input | 1 | 1 = divide the low 32 bits and sign-extend the result |
| dividend | input | XLEN (64) | Dividend |
| divisor | input | XLEN (64) | Divisor |
| result | output | XLEN (64) | Quotient or remainder, held between completions |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse marking a valid new `result` |

## Verification
The assertions check these properties on every cycle:
- the fixed results for zero divisors in full-width mode;
- the one-cycle turnaround of special cases;
- the exact busy window of N+1 cycles before `done`, in both widths;
- that `done` never coincides with `busy`;
- that the latched request cannot change while busy;
- the upper-half sign extension of every word-mode result.

Only the bench's scenarios can show that quotients and remainders are numerically right. That covers truncation toward zero, the remainder's sign, the overflow pair in both widths, and an extra `start` in mid-division being dropped without corrupting the answer.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;
  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } div_st_e;
endpackage

// File: rtl/intdiv_prep.sv
// Operand conditioning: width selection, magnitudes, special-case detection.
module intdiv_prep
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  input  div_op_e         op,
  input  logic            word,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg_q,
  output logic            neg_r,
  output logic            spec,
  output logic [XLEN-1:0] spec_val
);
  localparam int HI = XLEN - WLEN;

  logic            sgn, a_neg, b_neg, dz, ovf;
  logic [XLEN-1:0] ea, eb, abs_a, abs_b, min_v;

  always_comb begin
    sgn = ~op[0];
    if (word) begin
      ea    = {{HI{sgn & dividend[WLEN-1]}}, dividend[WLEN-1:0]};
      eb    = {{HI{sgn & divisor[WLEN-1]}},  divisor[WLEN-1:0]};
      min_v = {{(HI+1){1'b1}}, {(WLEN-1){1'b0}}};
    end else begin
      ea    = dividend;
      eb    = divisor;
      min_v = {1'b1, {(XLEN-1){1'b0}}};
    end
    a_neg = sgn & ea[XLEN-1];
    b_neg = sgn & eb[XLEN-1];
    abs_a = a_neg ? (~ea + XLEN'(1)) : ea;
    abs_b = b_neg ? (~eb + XLEN'(1)) : eb;
    // word magnitudes fit in WLEN bits; pre-align so only WLEN steps are needed
    mag_a = word ? (abs_a << WLEN) : abs_a;
    mag_b = abs_b;
    dz    = (eb == '0);
    ovf   = sgn && (ea == min_v) && (eb == '1);
    spec  = dz | ovf;
    neg_q = a_neg ^ b_neg;
    neg_r = a_neg;
    if (dz)       spec_val = op[1] ? ea : '1;
    else if (ovf) spec_val = op[1] ? '0 : ea;
    else          spec_val = '0;
  end
endmodule

// File: rtl/intdiv_core.sv
// Restoring shift-subtract on magnitudes, one quotient bit per clock.
module intdiv_core #(
  parameter int XLEN = 64,
  parameter int CW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CW-1:0]   steps,
  input  logic [XLEN-1:0] mag_a,
  input  logic [XLEN-1:0] mag_b,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem,
  output logic            last
);
  logic [XLEN-1:0] r_q, q_q, d_q, sub;
  logic [XLEN:0]   shifted;
  logic [CW-1:0]   cnt_q;
  logic            ge;

  always_comb begin
    shifted = {r_q, q_q[XLEN-1]};
    ge      = (shifted >= {1'b0, d_q});
    sub     = shifted[XLEN-1:0] - d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q   <= '0;
      q_q   <= '0;
      d_q   <= '0;
      cnt_q <= '0;
    end else if (load) begin
      r_q   <= '0;
      q_q   <= mag_a;
      d_q   <= mag_b;
      cnt_q <= steps;
    end else if (cnt_q != '0) begin
      r_q   <= ge ? sub : shifted[XLEN-1:0];
      q_q   <= {q_q[XLEN-2:0], ge};
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign quo  = q_q;
  assign rem  = r_q;
  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/intdiv_fixup.sv
// Sign restoration, special-value bypass and word-mode sign extension.
module intdiv_fixup
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] quo,
  input  logic [XLEN-1:0] rem,
  input  div_op_e         op,
  input  logic            word,
  input  logic            neg_q,
  input  logic            neg_r,
  input  logic            spec,
  input  logic [XLEN-1:0] spec_val,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] raw;

  always_comb begin
    if (spec)       raw = spec_val;
    else if (op[1]) raw = neg_r ? (~rem + XLEN'(1)) : rem;
    else            raw = neg_q ? (~quo + XLEN'(1)) : quo;
    res = word ? {{(XLEN-WLEN){raw[WLEN-1]}}, raw[WLEN-1:0]} : raw;
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import intdiv_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic            word,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic [XLEN-1:0] result,
  output logic            busy,
  output logic            done
);
  localparam int CW = $clog2(XLEN + 1);
  localparam logic [CW-1:0] STEPS_FULL = CW'(XLEN);
  localparam logic [CW-1:0] STEPS_WORD = CW'(WLEN);

  div_st_e         st_q;
  div_op_e         op_e, op_r, fx_op;
  logic            word_r, nq_r, nr_r;
  logic [XLEN-1:0] pre_ma, pre_mb, pre_sv, core_q, core_r, fx_res;
  logic            pre_nq, pre_nr, pre_spec, core_last, accept, load, in_fix;
  logic            fx_word, fx_nq, fx_nr, fx_spec;

  assign op_e   = div_op_e'(op);
  assign busy   = (st_q != ST_IDLE);
  assign accept = start && !busy;
  assign load   = accept && !pre_spec;
  assign in_fix = (st_q == ST_FIX);

  intdiv_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
    .dividend(dividend), .divisor(divisor), .op(op_e), .word(word),
    .mag_a(pre_ma), .mag_b(pre_mb), .neg_q(pre_nq), .neg_r(pre_nr),
    .spec(pre_spec), .spec_val(pre_sv)
  );

  intdiv_core #(.XLEN(XLEN), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load),
    .steps(word ? STEPS_WORD : STEPS_FULL),
    .mag_a(pre_ma), .mag_b(pre_mb),
    .quo(core_q), .rem(core_r), .last(core_last)
  );

  always_comb begin
    fx_op   = in_fix ? op_r   : op_e;
    fx_word = in_fix ? word_r : word;
    fx_nq   = in_fix ? nq_r   : pre_nq;
    fx_nr   = in_fix ? nr_r   : pre_nr;
    fx_spec = in_fix ? 1'b0   : pre_spec;
  end

  intdiv_fixup #(.XLEN(XLEN), .WLEN(WLEN)) u_fix (
    .quo(core_q), .rem(core_r), .op(fx_op), .word(fx_word),
    .neg_q(fx_nq), .neg_r(fx_nr), .spec(fx_spec), .spec_val(pre_sv),
    .res(fx_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_r   <= OP_DIV;
      word_r <= 1'b0;
      nq_r   <= 1'b0;
      nr_r   <= 1'b0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          op_r   <= op_e;
          word_r <= word;
          nq_r   <= pre_nq;
          nr_r   <= pre_nr;
          if (pre_spec) begin
            result <= fx_res;
            done   <= 1'b1;
          end else begin
            st_q <= ST_RUN;
          end
        end
        ST_RUN: if (core_last) st_q <= ST_FIX;
        ST_FIX: begin
          result <= fx_res;
          done   <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [1:0]      op,
  input logic            word,
  input logic [XLEN-1:0] dividend,
  input logic [XLEN-1:0] divisor,
  input logic [XLEN-1:0] result,
  input logic            busy,
  input logic            done,
  input logic            spec,
  input logic            word_r
);
  localparam int CNTW = $clog2(XLEN + 3);
  logic [CNTW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + CNTW'(1);
    else           bcnt <= '0;
  end

  // R4
  dz_quotient_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !word && divisor == '0 && !op[1] |=> done && result == '1);

  // R5
  dz_remainder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !word && divisor == '0 && op[1] |=> done && result == $past(dividend));

  // R8
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && word_r |-> result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}});

  // R9
  special_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && spec |=> done && !busy);

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !spec |=> busy && !done);

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(busy) |-> bcnt == (word_r ? CNTW'(WLEN + 1) : CNTW'(XLEN + 1)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(word_r));
endmodule

bind int_divider int_divider_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word),
  .dividend(dividend), .divisor(divisor), .result(result), .busy(busy),
  .done(done), .spec(pre_spec), .word_r(word_r)
);

// File: tb/test_int_divider.sv
`timescale 1ns/1ps
module test_int_divider;
  logic        clk = 1'b0;
  logic        rst_n, start, word;
  logic [1:0]  op;
  logic [63:0] dividend, divisor;
  logic [63:0] result;
  logic        busy, done;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  always #2.5 clk = ~clk;

  int_divider i_int_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word),
    .dividend(dividend), .divisor(divisor), .result(result),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 normal, 1 zero divisor, 2 signed overflow
  function automatic int kind(input logic [1:0] o, input bit w, input logic [63:0] a, input logic [63:0] b);
    if (w) begin
      if (b[31:0] == 32'h0) return 1;
      if (!o[0] && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF) return 2;
    end else begin
      if (b == 64'h0) return 1;
      if (!o[0] && a == MIN64 && b == '1) return 2;
    end
    return 0;
  endfunction

  function automatic logic [63:0] ref_res(input logic [1:0] o, input bit w, input logic [63:0] a, input logic [63:0] b);
    int sa, sb, r;
    int unsigned ua, ub;
    longint la, lb, lr;
    longint unsigned xa, xb;
    int k;
    k = kind(o, w, a, b);
    if (w) begin
      sa = a[31:0]; sb = b[31:0]; ua = a[31:0]; ub = b[31:0];
      case (o)
        2'd0: r = (k == 1) ? -1 : (k == 2) ? sa : sa / sb;
        2'd1: r = (k == 1) ? -1 : int'(ua / ub);
        2'd2: r = (k == 1) ? sa : (k == 2) ? 0 : sa % sb;
        default: r = (k == 1) ? int'(ua) : int'(ua % ub);
      endcase
      return {{32{r[31]}}, r[31:0]};
    end
    la = a; lb = b; xa = a; xb = b;
    case (o)
      2'd0: lr = (k == 1) ? -64'sd1 : (k == 2) ? la : la / lb;
      2'd1: lr = (k == 1) ? -64'sd1 : longint'(xa / xb);
      2'd2: lr = (k == 1) ? la : (k == 2) ? 64'sd0 : la % lb;
      default: lr = (k == 1) ? longint'(xa) : longint'(xa % xb);
    endcase
    return lr;
  endfunction

  function automatic string tag(input logic [1:0] o, input bit w, input int k);
    if (k == 1) return o[1] ? "R5" : "R4";
    if (k == 2) return o[1] ? "R7" : "R6";
    if (w) return "R8";
    return o[1] ? "R3" : "R2";
  endfunction

  task automatic run_op(input logic [1:0] o, input bit w, input logic [63:0] a, input logic [63:0] b, input bit intrude);
    logic [63:0] exp;
    int k, n;
    exp = ref_res(o, w, a, b);
    k = kind(o, w, a, b);
    n = w ? 32 : 64;
    @(negedge clk);
    start = 1'b1; op = o; word = w; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    if (k != 0) begin
      chk(done && !busy, "R9", {62'h0, busy, done}, 64'h1);
    end else begin
      for (int c = 0; c <= n; c++) begin
        chk(busy && !done, "R10", {62'h0, busy, done}, 64'h2);
        if (intrude && c == 3) begin
          start = 1'b1; dividend = ~a; divisor = b + 64'd3; op = ~o;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
      chk(done && !busy, "R10", {62'h0, busy, done}, 64'h1);
    end
    chk(result === exp, intrude ? "R11" : tag(o, w, k), result, exp);
    @(negedge clk);
    chk(!done && result === exp, "R12", result, exp);
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 7))
      0: return 64'h0;
      1: return 64'h1;
      2: return '1;
      3: return MIN64;
      4: return 64'h7FFF_FFFF_FFFF_FFFF;
      5: return 64'($urandom_range(0, 20));
      6: return {32'h0, $urandom};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'd0; word = 1'b0;
    dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 64'h0, "R1", result, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && result == 64'h0, "R1", result, 64'h0);

    // R2 signed/unsigned quotients, truncation toward zero
    run_op(2'd0, 0, 64'd100, 64'd7, 0);
    run_op(2'd0, 0, -64'sd100, 64'd7, 0);
    run_op(2'd1, 0, '1, 64'd3, 0);
    run_op(2'd1, 0, MIN64, '1, 0);
    // R3 remainder sign follows dividend
    run_op(2'd2, 0, -64'sd100, 64'd7, 0);
    run_op(2'd2, 0, 64'd100, -64'sd7, 0);
    run_op(2'd3, 0, '1, 64'd10, 0);
    // R4 / R5 zero divisor
    run_op(2'd0, 0, 64'd55, 64'd0, 0);
    run_op(2'd1, 0, 64'd55, 64'd0, 0);
    run_op(2'd2, 0, -64'sd9, 64'd0, 0);
    run_op(2'd3, 0, MIN64, 64'd0, 0);
    // R6 / R7 overflow pair
    run_op(2'd0, 0, MIN64, '1, 0);
    run_op(2'd2, 0, MIN64, '1, 0);
    // R8 word mode
    run_op(2'd0, 1, 64'h1234_5678_8000_0000, 64'hABCD_0000_FFFF_FFFF, 0);
    run_op(2'd2, 1, 64'h1234_5678_8000_0000, 64'h0000_0001_FFFF_FFFF, 0);
    run_op(2'd3, 1, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_0000_0000, 0);
    run_op(2'd1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 0);
    run_op(2'd0, 1, 64'h0000_0000_FFFF_FF9C, 64'h5555_5555_0000_0007, 0);
    // R11 start ignored while busy
    run_op(2'd0, 0, 64'd1000, 64'd33, 1);
    run_op(2'd3, 1, 64'd12345, 64'd77, 1);

    for (int i = 0; i < 150; i++) begin
      run_op(2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), pick(), pick(), 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule